// File: doc/BRIEF.md
# Cascadable Dual Timer with PWM

The block holds two 8-bit down-counters, called even and odd, that share one prescaler. Each counter moves once every eighth system clock. The counters can run on their own, each with its own reload byte and interrupt pulse. They can also be chained into one 16-bit counter. In chained mode the pair can also make a pulse-width-modulated waveform: it alternates between a low-phase and a high-phase 16-bit reload value, and it marks the end of each phase on a different interrupt line.

A toggle flip-flop follows the even end-of-count. The flip-flop reaches the pin only while the output-enable input is high. In PWM mode the flip-flop can also pick the first reload phase. Software sets up the block through a simple write port. Writing the control word starts every enabled counter from whatever count it holds at that moment.

Top module: `dual_timer_pwm`

## Requirements
- R1: Enabled counters change only on a prescale tick, which comes once every 8 clocks. A control write restarts the prescaler, so the first tick comes at the 8th clock edge after the write edge. A start count of N expires 8*N edges after the write.
- R2: In independent mode (control bit 2 = 0), each counter expires when it moves from 1 to 0 and pulses its own interrupt. If its reload bit is set (bit 4 for even, bit 5 for odd), it loads its low-reload byte, giving a period of 8*R clocks. If the bit is clear, it stays at zero and raises no more interrupts. A count of zero is idle. Bit 0 enables even and bit 1 enables odd.
- R3: In chained mode, the count is {odd, even}, with the even byte holding the least significant byte. Bit 0 enables the chain. A single interrupt fires, on irqEven, only when the full 16-bit value expires. irqOdd stays low.
- R4: In chained mode the counter always reloads from {oddLow, evenLow}, whatever reload bits 4 and 5 hold.
- R5: A control write makes no reload. Counting goes on from the current count.
- R6: In PWM mode (bits 2 and 3 set), expiry of the low phase pulses irqEven and loads the high value {oddHigh, evenHigh}. Expiry of the high phase pulses irqOdd and loads the low value. With toggle mode off (bit 6 = 0), the start count counts as a high phase, so its expiry loads the low value.
- R7: In PWM mode with toggle mode on (bit 6 = 1), a toggle level of 0 makes the start count's expiry load the high value and pulse irqEven. A toggle level of 1 makes it load the low value and pulse irqOdd.
- R8: Outside PWM mode, the toggle inverts on every irqEven pulse. In PWM mode it goes to 1 at the end of each low phase and to 0 at the end of each high phase.
- R9: Interrupts are one-clock pulses that follow the expiring tick. The toggle resets to 0. toutPin equals the toggle while outEn is 1 and is 0 while outEn is 0.
- R10: Write addresses are: 0 even count, 1 odd count, 2 even low reload, 3 odd low reload, 4 even high reload, 5 odd high reload, 6 control. Everything resets to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| outEn | input | 1 | Gates the toggle onto the pin |
| irqEven | output | 1 | Even-timer interrupt pulse |
| irqOdd | output | 1 | Odd-timer interrupt pulse |
| toutPin | output | 1 | Gated toggle output |

## Verification
The assertions assume that the prescale period is at least two clocks. They also assume that a count write in the same cycle as a decrement takes priority, so the decrement check skips those cycles. The bench keeps within these limits. It changes counts only while the counters are disabled or before the control write that starts them. It always measures intervals from a control write or from a previous interrupt, so every expected edge count is an exact multiple of eight.

// File: rtl/dtp_pkg.sv
package dtp_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CNT_EV = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_OD = 3'd1;
  localparam logic [ADDR_W-1:0] A_LO_EV  = 3'd2;
  localparam logic [ADDR_W-1:0] A_LO_OD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_HI_EV  = 3'd4;
  localparam logic [ADDR_W-1:0] A_HI_OD  = 3'd5;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd6;

  // strobes from control to datapath
  typedef struct packed {
    logic cascade;
    logic decEven;
    logic decOdd;
    logic rldEven;
    logic rldOdd;
    logic useHi;
  } strobe_t;
endpackage

// File: rtl/dtp_datapath.sv
module dtp_datapath
  import dtp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DW-1:0]     wrData,
  input  strobe_t           stb,
  output logic              evenOne,
  output logic              oddOne,
  output logic              wideOne,
  output logic              evenZero,
  output logic              oddZero,
  output logic              wideZero
);
  localparam int WW = 2 * DW;
  localparam logic [DW-1:0] ONE = DW'(1);
  localparam logic [WW-1:0] WONE = WW'(1);

  logic [DW-1:0] cntEv, cntOd, loEv, loOd, hiEv, hiOd;
  logic [DW-1:0] nextEv, nextOd;
  logic [WW-1:0] wide, wideLo, wideHi;

  assign wide   = {cntOd, cntEv};
  assign wideLo = {loOd, loEv};
  assign wideHi = {hiOd, hiEv};

  assign evenOne  = (cntEv == ONE);
  assign oddOne   = (cntOd == ONE);
  assign wideOne  = (wide == WONE);
  assign evenZero = (cntEv == '0);
  assign oddZero  = (cntOd == '0);
  assign wideZero = (wide == '0);

  always_comb begin
    nextEv = cntEv;
    nextOd = cntOd;
    if (stb.cascade) begin
      if (stb.rldEven)      {nextOd, nextEv} = stb.useHi ? wideHi : wideLo;
      else if (stb.decEven) {nextOd, nextEv} = wide - WONE;
    end else begin
      if (stb.rldEven)      nextEv = loEv;
      else if (stb.decEven) nextEv = cntEv - ONE;
      if (stb.rldOdd)       nextOd = loOd;
      else if (stb.decOdd)  nextOd = cntOd - ONE;
    end
    if (wrEn && wrAddr == A_CNT_EV) nextEv = wrData;
    if (wrEn && wrAddr == A_CNT_OD) nextOd = wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntEv <= '0; cntOd <= '0;
      loEv  <= '0; loOd  <= '0;
      hiEv  <= '0; hiOd  <= '0;
    end else begin
      cntEv <= nextEv;
      cntOd <= nextOd;
      if (wrEn && wrAddr == A_LO_EV) loEv <= wrData;
      if (wrEn && wrAddr == A_LO_OD) loOd <= wrData;
      if (wrEn && wrAddr == A_HI_EV) hiEv <= wrData;
      if (wrEn && wrAddr == A_HI_OD) hiOd <= wrData;
    end
  end

  // R2: a plain independent decrement lowers the even count by exactly one
  p_dec_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.decEven && !stb.rldEven && !stb.cascade && !(wrEn && wrAddr == A_CNT_EV))
    |-> cntEv == $past(cntEv) - ONE);

  // R4: a chained reload lands on one of the two programmed 16-bit values
  p_casc_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.cascade && stb.rldEven && !wrEn)
    |-> (wide == $past(wideLo)) || (wide == $past(wideHi)));
endmodule

// File: rtl/dtp_ctrl.sv
module dtp_ctrl
  import dtp_pkg::*;
#(
  parameter int PRESCALE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [6:0]        wrCtrl,
  input  logic              evenOne,
  input  logic              oddOne,
  input  logic              wideOne,
  input  logic              evenZero,
  input  logic              oddZero,
  input  logic              wideZero,
  output strobe_t           stb,
  output logic              irqEven,
  output logic              irqOdd,
  output logic              toggle
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);
  localparam logic [PW-1:0] PONE  = PW'(1);

  logic enEven, enOdd, cascade, pwm, autoEven, autoOdd, toutMode;
  logic [PW-1:0] presc;
  logic tick, ctrlWr, inHigh;
  logic fireEv, fireOd, wideExp;

  assign ctrlWr = wrEn && (wrAddr == A_CTRL);
  assign tick   = (presc == PLAST) && !ctrlWr;

  always_comb begin
    stb = '0;
    stb.cascade = cascade;
    fireEv  = 1'b0;
    fireOd  = 1'b0;
    wideExp = 1'b0;
    if (tick) begin
      if (cascade) begin
        if (enEven && !wideZero) begin
          if (wideOne) begin
            wideExp     = 1'b1;
            stb.rldEven = 1'b1;
            stb.useHi   = pwm && !inHigh;
            if (pwm && inHigh) fireOd = 1'b1;
            else               fireEv = 1'b1;
          end else begin
            stb.decEven = 1'b1;
          end
        end
      end else begin
        if (enEven && !evenZero) begin
          fireEv = evenOne;
          if (evenOne && autoEven) stb.rldEven = 1'b1;
          else                     stb.decEven = 1'b1;
        end
        if (enOdd && !oddZero) begin
          fireOd = oddOne;
          if (oddOne && autoOdd) stb.rldOdd = 1'b1;
          else                   stb.decOdd = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {enEven, enOdd, cascade, pwm, autoEven, autoOdd, toutMode} <= '0;
      presc   <= '0;
      inHigh  <= 1'b0;
      toggle  <= 1'b0;
      irqEven <= 1'b0;
      irqOdd  <= 1'b0;
    end else begin
      irqEven <= fireEv;
      irqOdd  <= fireOd;
      if (ctrlWr) begin
        {toutMode, autoOdd, autoEven, pwm, cascade, enOdd, enEven} <= wrCtrl;
        presc  <= '0;
        inHigh <= wrCtrl[6] ? toggle : 1'b1;
      end else begin
        presc <= (presc == PLAST) ? '0 : presc + PONE;
        if (wideExp && pwm) begin
          inHigh <= !inHigh;
          toggle <= !inHigh;
        end else if (fireEv) begin
          toggle <= !toggle;
        end
      end
    end
  end

  // R1: prescale ticks never come on consecutive clocks
  p_tick_spacing_r1: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> !tick);

  // R9: interrupts are one-cycle pulses
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqEven || irqOdd) |=> !(irqEven || irqOdd));

  // R3: chained non-PWM mode never raises the odd interrupt
  p_casc_no_odd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cascade && !pwm && !$past(ctrlWr)) |-> !irqOdd);

  // R8: in PWM mode the odd interrupt comes with the toggle low, the even one with it high
  p_pwm_level_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cascade && pwm && !$past(ctrlWr) && (irqEven || irqOdd)) |-> (toggle == irqEven));
endmodule

// File: rtl/dual_timer_pwm.sv
module dual_timer_pwm
  import dtp_pkg::*;
#(
  parameter int DW       = 8,
  parameter int PRESCALE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DW-1:0]     wrData,
  input  logic              outEn,
  output logic              irqEven,
  output logic              irqOdd,
  output logic              toutPin
);
  strobe_t stb;
  logic evenOne, oddOne, wideOne, evenZero, oddZero, wideZero, toggle;

  dtp_ctrl #(.PRESCALE(PRESCALE)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrCtrl(wrData[6:0]),
    .evenOne(evenOne), .oddOne(oddOne), .wideOne(wideOne),
    .evenZero(evenZero), .oddZero(oddZero), .wideZero(wideZero),
    .stb(stb), .irqEven(irqEven), .irqOdd(irqOdd), .toggle(toggle)
  );

  dtp_datapath #(.DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .stb(stb),
    .evenOne(evenOne), .oddOne(oddOne), .wideOne(wideOne),
    .evenZero(evenZero), .oddZero(oddZero), .wideZero(wideZero)
  );

  assign toutPin = toggle & outEn;
endmodule

// File: tb/sim_dual_timer_pwm.sv
`timescale 1ns/100ps
module sim_dual_timer_pwm;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic outEn = 1'b1;
  logic irqEven, irqOdd, toutPin;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dual_timer_pwm u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .outEn(outEn), .irqEven(irqEven), .irqOdd(irqOdd), .toutPin(toutPin)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  // waits for an interrupt; k = edges since the previous reference point, 0 if none
  task automatic waitIrq(input int limit, output int k, output bit ev, output bit od);
    k = 0; ev = 0; od = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (irqEven || irqOdd) begin
        k = i; ev = irqEven; od = irqOdd;
        return;
      end
    end
  endtask

  task automatic expectIrq(input string req, input int expK, input bit expEv, input bit expOd);
    int k; bit ev; bit od;
    waitIrq(expK + 40, k, ev, od);
    check(k == expK, req, k, expK);
    check(ev == expEv && od == expOd, req, {ev, od}, {expEv, expOd});
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int k; bit ev; bit od;
    doReset();
    // R9 R10 reset state
    check(!irqEven && !irqOdd, "R10 reset irqs", {irqEven, irqOdd}, 0);
    check(!toutPin, "R9 reset pin", toutPin, 0);

    // R1 R2 R8: independent even with reload, several counts
    for (int n = 1; n <= 7; n += 2) begin
      doReset();
      wr(3'd0, 8'(n)); wr(3'd2, 8'(n + 1)); wr(3'd6, 8'h11);
      expectIrq("R1 first expiry", 8 * n, 1, 0);
      @(negedge clk);
      check(!irqEven, "R9 pulse width", irqEven, 0);
      check(toutPin, "R8 toggle first", toutPin, 1);
      waitIrq(8 * (n + 1) + 40, k, ev, od);
      check(k == 8 * (n + 1) - 1, "R2 reload period", k, 8 * (n + 1) - 1);
      check(!toutPin, "R8 toggle second", toutPin, 0);
    end

    // R2: odd without reload stops, even disabled stays quiet
    doReset();
    wr(3'd1, 8'd3); wr(3'd3, 8'd9); wr(3'd0, 8'd4); wr(3'd6, 8'h02);
    expectIrq("R2 odd expiry", 24, 0, 1);
    waitIrq(2400, k, ev, od);
    check(k == 0, "R2 no reload stop", k, 0);

    // R3 R4: chained 258 then reload 3, reload bits clear
    doReset();
    wr(3'd0, 8'h02); wr(3'd1, 8'h01); wr(3'd2, 8'h03); wr(3'd3, 8'h00);
    wr(3'd6, 8'h05);
    expectIrq("R3 chained expiry", 2064, 1, 0);
    expectIrq("R4 chained reload", 24, 1, 0);
    expectIrq("R4 chained reload again", 24, 1, 0);

    // R5: control rewrite mid-count continues from current count
    doReset();
    wr(3'd0, 8'd10); wr(3'd2, 8'd2); wr(3'd6, 8'h11);
    for (int i = 0; i < 32; i++) @(negedge clk);
    wr(3'd6, 8'h11);
    expectIrq("R5 no reload on control write", 48, 1, 0);

    // R6 R8: PWM without toggle mode, two reload pairs
    for (int p = 0; p < 2; p++) begin
      int lo = (p == 0) ? 3 : 1;
      int hi = (p == 0) ? 5 : 4;
      doReset();
      wr(3'd0, 8'd2); wr(3'd1, 8'd0);
      wr(3'd2, 8'(lo)); wr(3'd3, 8'd0); wr(3'd4, 8'(hi)); wr(3'd5, 8'd0);
      wr(3'd6, 8'h0D);
      expectIrq("R6 start expiry loads low", 16, 0, 1);
      check(!toutPin, "R8 pwm high end", toutPin, 0);
      expectIrq("R6 low phase", 8 * lo, 1, 0);
      check(toutPin, "R8 pwm low end", toutPin, 1);
      expectIrq("R6 high phase", 8 * hi, 0, 1);
      check(!toutPin, "R8 pwm high end 2", toutPin, 0);
      expectIrq("R6 low phase 2", 8 * lo, 1, 0);
    end

    // R7: toggle mode, toggle low picks high first
    doReset();
    wr(3'd0, 8'd1); wr(3'd1, 8'd0);
    wr(3'd2, 8'd2); wr(3'd3, 8'd0); wr(3'd4, 8'd3); wr(3'd5, 8'd0);
    wr(3'd6, 8'h4D);
    expectIrq("R7 toggle low start", 8, 1, 0);
    check(toutPin, "R7 toggle now high", toutPin, 1);
    outEn = 1'b0;
    @(negedge clk);
    check(!toutPin, "R9 pin gated", toutPin, 0);
    outEn = 1'b1;
    expectIrq("R7 high loaded", 23, 0, 1);
    expectIrq("R7 low follows", 16, 1, 0);
    // toggle now high: restart picks low first
    wr(3'd6, 8'h00);
    wr(3'd0, 8'd2); wr(3'd1, 8'd0);
    wr(3'd6, 8'h4D);
    expectIrq("R7 toggle high start", 16, 0, 1);
    check(!toutPin, "R7 toggle now low", toutPin, 0);
    expectIrq("R7 low loaded", 16, 1, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule